// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache that does not allocate on write misses and a slow memory. Each processor store goes into the cache and into this block in the same cycle. A store that misses the cache goes into this block only. The block keeps a small first-in first-out queue of pending stores. A drain engine on the memory side retires the queue head to memory through a request/acknowledge handshake, independently of the processor.

When stores arrive faster than memory can retire them, the queue fills. The block then holds the processor with a stall output until a slot frees. No store is lost. A read-check port compares a read-miss address against every pending entry. It flags a hazard so the read waits until the matching store has reached memory. An empty flag tells the processor that every accepted store has been written.

Each entry holds a 32-bit word address, 32 bits of data and 4 byte enables. The queue depth is a parameter, with a default of 4.

Top module: `wt_store_buffer`

## Requirements
- R1: While reset is asserted and after its release, with no stores yet accepted: `sb_empty` is 1, and `mem_req`, `st_stall` and `rd_hazard` are 0.
- R2: Accepted stores are presented on `mem_addr`, `mem_data` and `mem_be` in the order they were accepted. Address, data and byte enables are unchanged.
- R3: The queue holds at most DEPTH (4) entries. With DEPTH entries pending, a store with `st_valid`=1 gets `st_stall`=1 in the same cycle, unless a drain completes in that cycle. A store presented while `st_stall`=1 is not captured.
- R4: No store is dropped. A store held on the port while stalled is captured in the first cycle in which `st_stall` is 0.
- R5: When the queue is full and, in the same cycle, a store arrives and a drain completes (`mem_req`=1 and `mem_ack`=1), both are accepted and `st_stall` is 0.
- R6: `mem_req` is 1 exactly when at least one entry is pending. While `mem_req`=1 and `mem_ack`=0, the head's address, data and byte enables are held for the next cycle.
- R7: In the same cycle, `rd_hazard` is 1 exactly when `rd_check`=1 and `rd_addr` equals the address of some pending entry. This includes the head entry being drained in that cycle.
- R8: A pending entry stops causing a hazard from the cycle after the edge at which its drain handshake completed.
- R9: `sb_empty` is 1 exactly when no entry is pending. It rises the cycle after the last entry's drain handshake.
- R10: A store accepted into an empty queue appears on `mem_req` and the memory fields from the cycle after its capture edge. It does not appear in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store present |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle; hold it |
| rd_check | input | 1 | Read-miss address valid for hazard check |
| rd_addr | input | 32 | Read-miss word address |
| rd_hazard | output | 1 | Read address matches a pending store |
| mem_req | output | 1 | Head entry offered to memory |
| mem_addr | output | 32 | Head entry address |
| mem_data | output | 32 | Head entry data |
| mem_be | output | 4 | Head entry byte enables |
| mem_ack | input | 1 | Memory takes the head entry this cycle |
| sb_empty | output | 1 | All accepted stores have reached memory |

## Verification
The bench targets the full-queue cycle in which a store and a drain coincide. A design that looks only at the full flag there would stall needlessly. A design that ignores the full flag would overwrite the head and lose a store. The bench runs a long sweep over every occupancy with mixed acknowledge patterns and a small address set. The sweep catches pointer wrap errors, which show up as reordered or duplicated memory writes. It also catches hazard logic that misses stale slots or drops the entry being drained. It probes the emptying edge, where an empty flag raised one cycle early would tell software that stores had landed before they had.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int WSB_ADDR_W = 32;
  localparam int WSB_DATA_W = 32;
  localparam int WSB_BE_W   = WSB_DATA_W / 8;

  typedef struct packed {
    logic [WSB_ADDR_W-1:0] addr;
    logic [WSB_DATA_W-1:0] data;
    logic [WSB_BE_W-1:0]   be;
  } wsb_entry_t;
endpackage

// File: rtl/wsb_queue.sv
module wsb_queue
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  wsb_entry_t       push_ent,
  output wsb_entry_t       head_ent,
  output logic             head_vld,
  output logic             full,
  output logic             empty,
  output wsb_entry_t       slot_ent [DEPTH],
  output logic [DEPTH-1:0] slot_vld
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  wsb_entry_t       store_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;

  // next-state
  always_comb begin
    vld_d    = vld_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (pop) begin
      vld_d[rd_ptr_q] = 1'b0;
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push) begin
      vld_d[wr_ptr_q] = 1'b1;
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      vld_q    <= vld_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // payload storage, write-enabled per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we;
    assign we = push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we) store_q[i] <= push_ent;
    end
    assign slot_ent[i] = store_q[i];
  end

  assign slot_vld = vld_q;
  assign head_ent = store_q[rd_ptr_q];
  assign head_vld = vld_q[rd_ptr_q];
  assign full     = &vld_q;
  assign empty    = ~|vld_q;
endmodule

// File: rtl/wsb_match.sv
module wsb_match
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  wsb_entry_t             slot_ent [DEPTH],
  input  logic [DEPTH-1:0]       slot_vld,
  input  logic                   rd_check,
  input  logic [WSB_ADDR_W-1:0]  rd_addr,
  output logic                   hazard
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = slot_vld[i] && (slot_ent[i].addr == rd_addr);
  end

  assign hazard = rd_check && (|hit);
endmodule

// File: rtl/wsb_drain.sv
module wsb_drain
  import wsb_pkg::*;
(
  input  logic                  head_vld,
  input  wsb_entry_t            head_ent,
  input  logic                  mem_ack,
  output logic                  mem_req,
  output logic [WSB_ADDR_W-1:0] mem_addr,
  output logic [WSB_DATA_W-1:0] mem_data,
  output logic [WSB_BE_W-1:0]   mem_be,
  output logic                  pop
);
  assign mem_req  = head_vld;
  assign mem_addr = head_ent.addr;
  assign mem_data = head_ent.data;
  assign mem_be   = head_ent.be;
  assign pop      = head_vld && mem_ack;
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [WSB_ADDR_W-1:0] st_addr,
  input  logic [WSB_DATA_W-1:0] st_data,
  input  logic [WSB_BE_W-1:0]   st_be,
  output logic                  st_stall,
  input  logic                  rd_check,
  input  logic [WSB_ADDR_W-1:0] rd_addr,
  output logic                  rd_hazard,
  output logic                  mem_req,
  output logic [WSB_ADDR_W-1:0] mem_addr,
  output logic [WSB_DATA_W-1:0] mem_data,
  output logic [WSB_BE_W-1:0]   mem_be,
  input  logic                  mem_ack,
  output logic                  sb_empty
);
  wsb_entry_t       push_ent, head_ent;
  wsb_entry_t       slot_ent [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  logic             head_vld, full, empty, push, pop;

  assign push_ent = '{addr: st_addr, data: st_data, be: st_be};
  // a drain in the same cycle frees the slot the new store needs
  assign push     = st_valid && (!full || pop);
  assign st_stall = st_valid && full && !pop;
  assign sb_empty = empty;

  wsb_queue #(.DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_ent(push_ent), .head_ent(head_ent), .head_vld(head_vld),
    .full(full), .empty(empty), .slot_ent(slot_ent), .slot_vld(slot_vld)
  );

  wsb_match #(.DEPTH(DEPTH)) match_i (
    .slot_ent(slot_ent), .slot_vld(slot_vld), .rd_check(rd_check),
    .rd_addr(rd_addr), .hazard(rd_hazard)
  );

  wsb_drain drain_i (
    .head_vld(head_vld), .head_ent(head_ent), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .pop(pop)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker
  import wsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic                  st_stall,
  input logic                  rd_check,
  input logic                  rd_hazard,
  input logic                  mem_req,
  input logic [WSB_ADDR_W-1:0] mem_addr,
  input logic [WSB_DATA_W-1:0] mem_data,
  input logic [WSB_BE_W-1:0]   mem_be,
  input logic                  mem_ack,
  input logic                  sb_empty
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;
  logic [OCC_W-1:0] occ_q, occ_d;

  // occupancy seen at the ports
  always_comb begin
    occ_d = occ_q;
    if (st_valid && !st_stall) occ_d = occ_d + 1'b1;
    if (mem_req && mem_ack)    occ_d = occ_d - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (st_valid && mem_req && !mem_ack && occ_q == OCC_W'(DEPTH)));

  assert_empty_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) == sb_empty);

  assert_req_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == !sb_empty);

  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  assert_hazard_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hazard |-> (rd_check && mem_req));
endmodule

bind wt_store_buffer wsb_checker #(.DEPTH(DEPTH)) checker_i (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
  .rd_check(rd_check), .rd_hazard(rd_hazard), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
  .mem_ack(mem_ack), .sb_empty(sb_empty)
);

// File: tb/wt_store_buffer_tb_top.sv
`timescale 1ns/1ps
module wt_store_buffer_tb_top;
  localparam int DEPTH = 4;

  logic        clk, rst_n;
  logic        st_valid, rd_check, mem_ack;
  logic [31:0] st_addr, st_data, rd_addr;
  logic [3:0]  st_be;
  logic        st_stall, rd_hazard, mem_req, sb_empty;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference queue
  logic [31:0] m_addr [DEPTH];
  logic [31:0] m_data [DEPTH];
  logic [3:0]  m_be   [DEPTH];
  int          m_cnt = 0;

  wt_store_buffer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
    .rd_check(rd_check), .rd_addr(rd_addr), .rd_hazard(rd_hazard),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_ack(mem_ack), .sb_empty(sb_empty)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model
  task automatic step(input bit sv, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit ack, input bit rc,
                      input logic [31:0] ra);
    bit e_stall, e_haz, popped;
    @(negedge clk);
    st_valid = sv; st_addr = a; st_data = d; st_be = be;
    mem_ack = ack; rd_check = rc; rd_addr = ra;
    #2;
    popped  = ack && (m_cnt > 0);
    e_stall = sv && (m_cnt == DEPTH) && !popped;
    e_haz   = 1'b0;
    for (int i = 0; i < m_cnt; i++) if (rc && m_addr[i] == ra) e_haz = 1'b1;
    chk("R6 mem_req", 32'(mem_req), 32'(m_cnt > 0));
    chk("R9 sb_empty", 32'(sb_empty), 32'(m_cnt == 0));
    chk("R3 R5 st_stall", 32'(st_stall), 32'(e_stall));
    chk("R7 R8 rd_hazard", 32'(rd_hazard), 32'(e_haz));
    if (m_cnt > 0) begin
      chk("R2 mem_addr", mem_addr, m_addr[0]);
      chk("R2 mem_data", mem_data, m_data[0]);
      chk("R2 mem_be", 32'(mem_be), 32'(m_be[0]));
    end
    if (popped) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1]; m_be[i] = m_be[i+1];
      end
      m_cnt--;
    end
    if (sv && !e_stall) begin
      m_addr[m_cnt] = a; m_data[m_cnt] = d; m_be[m_cnt] = be;
      m_cnt++;
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    mem_ack = 0; rd_check = 0; rd_addr = 0;
    #15;
    // R1 reset state
    chk("R1 empty in reset", 32'(sb_empty), 32'd1);
    chk("R1 req in reset", 32'(mem_req), 32'd0);
    chk("R1 stall in reset", 32'(st_stall), 32'd0);
    chk("R1 hazard in reset", 32'(rd_hazard), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 1, 32'h0);   // R1 after release

    // R10: store into empty queue, visible from next cycle
    step(1, 32'h40, 32'hA0A0_0001, 4'hF, 0, 1, 32'h40); // hazard 0 same cycle
    step(0, 0, 0, 0, 0, 1, 32'h40);                     // R10, R7 now hazard

    // R3: fill, 5th store stalls and holds
    step(1, 32'h44, 32'hA0A0_0002, 4'h3, 0, 0, 0);
    step(1, 32'h48, 32'hA0A0_0003, 4'hC, 0, 0, 0);
    step(1, 32'h4C, 32'hA0A0_0004, 4'h1, 0, 0, 0);
    for (int k = 0; k < 3; k++) step(1, 32'h50, 32'hA0A0_0005, 4'h8, 0, 1, 32'h50);
    // R5/R4: full with simultaneous drain accepts stalled store
    step(1, 32'h50, 32'hA0A0_0005, 4'h8, 1, 1, 32'h40); // head hazard R7
    // R8: drained address no longer hazards
    step(0, 0, 0, 0, 0, 1, 32'h40);
    step(0, 0, 0, 0, 0, 1, 32'h50);
    // drain everything, check R9 rise
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, 1, 32'h50);

    // near-exhaustive sweep: small address set, mixed ack patterns
    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], 32'h100 + 32'(lfsr[3:1]) * 4, {lfsr, 16'(n)},
           lfsr[9:6], (n % 97 < 40) ? lfsr[11] & lfsr[4] : lfsr[11] | lfsr[4],
           lfsr[12], 32'h100 + 32'(lfsr[15:13]) * 4);
    end
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0); // R9 empty after full drain

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule